// File: doc/BRIEF.md
# Debug Memory Access Handshake Controller

This block lets an external debug probe act as the memory behind a processor's debug memory area. When the processor issues a load or store to that area, the block holds the processor stalled, raises a pending flag and records the address, the direction, the access size and, for stores, the data moved onto its byte lanes. The probe polls a small parallel register port, inspects the captured access, supplies load data through the data register and clears the pending flag to let the processor continue.

A reset-seen flag is set by every processor reset. While it is set, the block discards any control write that still carries the flag as 1. This means the probe must acknowledge the reset before it can complete an access, so it cannot finish an access that arrived after the reset by mistake. A routing-enable bit decides whether processor requests reach the probe at all. Its value after reset is a parameter.

Top module: `dbg_pacc_ctrl`

## Requirements
- R1: After reset the control word (bit 0 pending, bit 1 store direction, bits 3:2 size, bit 4 routing enable, bit 5 reset-seen) reads pending=0, reset-seen=1, routing enable=ROUTE_RST, and cpu_ready is 0.
- R2: A processor request while routing is enabled and nothing is pending sets pending on the next edge. It also latches the address, direction (1 = store) and size (0 byte, 1 halfword, 2 word) into the control word and the address register (select 1).
- R3: While routing enable is 0, a processor request is not flagged: pending stays 0 and cpu_ready stays 0.
- R4: While pending is 1, cpu_ready stays 0. Pending is never cleared except by an accepted probe clear or by reset.
- R5: An accepted control write with bit 0 = 0 while pending clears pending on that edge. cpu_ready is then 1 for exactly one cycle.
- R6: A store puts the processor's right-justified write data into the data register (select 2) on byte lanes starting at byte addr[1:0], spanning 1, 2 or 4 bytes by size, with the other lanes 0. For example, a halfword 0x5678 at 0xFF201232 reads back as 0x56780000.
- R7: During the cpu_ready cycle, cpu_rdata is the data-register bytes selected by the latched size and addr[1:0], right-justified and zero-filled. At all other times cpu_rdata is 0.
- R8: While reset-seen is 1, a control write with bit 5 = 1 is discarded entirely: pending and routing enable keep their values.
- R9: A control write with bit 5 = 0 is accepted. It clears reset-seen, loads routing enable from bit 4 and, if bit 0 is 0, completes a pending access.
- R10: A reset during a pending access clears pending, sets reset-seen and produces no cpu_ready pulse.
- R11: The probe cannot set reset-seen: once it is 0, only reset makes it 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low processor reset |
| cpu_req | input | 1 | Processor debug-area access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | ADDR_W | Access address |
| cpu_wdata | input | DATA_W | Right-justified store data |
| cpu_ready | output | 1 | One-cycle completion strobe |
| cpu_rdata | output | DATA_W | Right-justified load data, valid with cpu_ready |
| prb_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| prb_wr | input | 1 | Probe write strobe (control or data) |
| prb_wdata | input | DATA_W | Probe write value |
| prb_rdata | output | DATA_W | Selected register value |

## Verification
The bench builds the block with its defaults: 32-bit address and data, and routing enabled after reset. With routing enabled after reset, a request that is held across a reset becomes pending again at once. This brings the stale-completion scenario within reach: a clear attempted under reset-seen, then the acknowledge, then the real completion. The 32-bit width exposes all four byte offsets for byte accesses and both halfword positions, which random accesses cover in both directions.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } dbgp_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } dbgp_size_e;

  // control word bit positions
  localparam int CB_PEND  = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_SZ_LO = 2;
  localparam int CB_ROUTE = 4;
  localparam int CB_RSEEN = 5;

endpackage

// File: rtl/dbgp_lanes.sv
module dbgp_lanes
  import dbgp_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] vec_in,
  output logic [DATA_W-1:0] placed,
  output logic [DATA_W-1:0] picked
);

  localparam int SH_W = OFF_W + 3;

  function automatic int span_of(input logic [1:0] s);
    case (dbgp_size_e'(s))
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return LANES;
    endcase
  endfunction

  logic [LANES-1:0]  byte_en;
  logic [DATA_W-1:0] lane_mask;
  logic [SH_W-1:0]   shamt;
  int                span;

  assign span  = span_of(size);
  assign shamt = {off, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign byte_en[i] = (i >= int'(off)) && (i < int'(off) + span);
    assign lane_mask[i*8 +: 8] = {8{byte_en[i]}};
  end

  assign placed = (vec_in << shamt) & lane_mask;
  assign picked = (vec_in & lane_mask) >> shamt;

endmodule

// File: rtl/dbgp_ctrl.sv
module dbgp_ctrl
  import dbgp_pkg::*;
#(
  parameter bit ROUTE_RST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req,
  input  logic       cpu_we,
  input  logic [1:0] cpu_size,
  input  logic       ctrl_wr,
  input  logic       wr_pend,
  input  logic       wr_route,
  input  logic       wr_rseen,
  output logic       pend,
  output logic       dir_wr,
  output logic [1:0] sz,
  output logic       route_en,
  output logic       rseen,
  output logic       ready_q,
  output logic       cap_evt,
  output logic       done_evt,
  output logic       drop_evt
);

  logic accept;

  assign accept   = ctrl_wr && (!rseen || !wr_rseen);
  assign drop_evt = ctrl_wr && rseen && wr_rseen;
  assign done_evt = accept && pend && !wr_pend;
  assign cap_evt  = cpu_req && route_en && !pend && !ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      dir_wr   <= 1'b0;
      sz       <= SZ_BYTE;
      route_en <= ROUTE_RST;
      rseen    <= 1'b1;
      ready_q  <= 1'b0;
    end else begin
      ready_q <= done_evt;
      if (cap_evt) begin
        pend   <= 1'b1;
        dir_wr <= cpu_we;
        sz     <= cpu_size;
      end else if (done_evt) begin
        pend <= 1'b0;
      end
      if (accept) begin
        route_en <= wr_route;
        rseen    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dbgp_capture.sv
module dbgp_capture #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_evt,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] placed,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] prb_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (cap_evt) addr_q <= cpu_addr;
      // a captured store takes the data register over a probe write
      if (cap_evt && cpu_we) data_q <= placed;
      else if (data_wr)      data_q <= prb_wdata;
    end
  end

endmodule

// File: rtl/dbg_pacc_ctrl.sv
module dbg_pacc_ctrl
  import dbgp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter bit ROUTE_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [1:0]        prb_sel,
  input  logic              prb_wr,
  input  logic [DATA_W-1:0] prb_wdata,
  output logic [DATA_W-1:0] prb_rdata
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic              pend, dir_wr, route_en, rseen, ready_q;
  logic [1:0]        sz;
  logic              cap_evt, done_evt, drop_evt;
  logic              ctrl_wr, data_wr;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, placed, picked, unused_pick, unused_place;
  logic [DATA_W-1:0] ctrl_word;

  assign ctrl_wr = prb_wr && (dbgp_sel_e'(prb_sel) == SEL_CTRL);
  assign data_wr = prb_wr && (dbgp_sel_e'(prb_sel) == SEL_DATA);

  dbgp_ctrl #(.ROUTE_RST(ROUTE_RST)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_size (cpu_size),
    .ctrl_wr  (ctrl_wr),
    .wr_pend  (prb_wdata[CB_PEND]),
    .wr_route (prb_wdata[CB_ROUTE]),
    .wr_rseen (prb_wdata[CB_RSEEN]),
    .pend     (pend),
    .dir_wr   (dir_wr),
    .sz       (sz),
    .route_en (route_en),
    .rseen    (rseen),
    .ready_q  (ready_q),
    .cap_evt  (cap_evt),
    .done_evt (done_evt),
    .drop_evt (drop_evt)
  );

  // store path: position incoming data on its lanes
  dbgp_lanes #(.DATA_W(DATA_W)) u_place (
    .off    (cpu_addr[OFF_W-1:0]),
    .size   (cpu_size),
    .vec_in (cpu_wdata),
    .placed (placed),
    .picked (unused_pick)
  );

  // load path: pull the latched lanes back to bit 0
  dbgp_lanes #(.DATA_W(DATA_W)) u_pick (
    .off    (addr_q[OFF_W-1:0]),
    .size   (sz),
    .vec_in (data_q),
    .placed (unused_place),
    .picked (picked)
  );

  dbgp_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_evt   (cap_evt),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .placed    (placed),
    .data_wr   (data_wr),
    .prb_wdata (prb_wdata),
    .addr_q    (addr_q),
    .data_q    (data_q)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CB_PEND]              = pend;
    ctrl_word[CB_DIR]               = dir_wr;
    ctrl_word[CB_SZ_LO +: 2]        = sz;
    ctrl_word[CB_ROUTE]             = route_en;
    ctrl_word[CB_RSEEN]             = rseen;
  end

  always_comb begin
    case (dbgp_sel_e'(prb_sel))
      SEL_CTRL: prb_rdata = ctrl_word;
      SEL_ADDR: prb_rdata = DATA_W'(addr_q);
      SEL_DATA: prb_rdata = data_q;
      default:  prb_rdata = '0;
    endcase
  end

  assign cpu_ready = ready_q;
  assign cpu_rdata = ready_q ? picked : '0;

endmodule

// File: rtl/dbgp_chk.sv
module dbgp_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              pend,
  input logic              route_en,
  input logic              rseen,
  input logic              cap_evt,
  input logic              done_evt,
  input logic              drop_evt
);

  p_cap_sets_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> pend);

  p_no_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_en && !pend) |=> !pend);

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !cpu_ready);

  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !done_evt) |=> pend);

  p_done_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (cpu_ready && !pend));

  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_rdata_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> (cpu_rdata == '0));

  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (rseen && route_en == $past(route_en) && (pend || !$past(pend))));

  p_rseen_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rseen |=> !rseen);

endmodule

bind dbg_pacc_ctrl dbgp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_ready (cpu_ready),
  .cpu_rdata (cpu_rdata),
  .pend      (pend),
  .route_en  (route_en),
  .rseen     (rseen),
  .cap_evt   (cap_evt),
  .done_evt  (done_evt),
  .drop_evt  (drop_evt)
);

// File: tb/dbg_pacc_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_pacc_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic [1:0]  prb_sel = 2'd0;
  logic        prb_wr = 1'b0;
  logic [31:0] prb_wdata = '0;
  logic [31:0] prb_rdata;

  int total = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  dbg_pacc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .prb_sel(prb_sel),
    .prb_wr(prb_wr), .prb_wdata(prb_wdata), .prb_rdata(prb_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_place(input logic [31:0] w, input logic [1:0] off, input logic [1:0] s);
    logic [31:0] r = '0;
    for (int k = 0; k < nbytes(s); k++) r[(int'(off)+k)*8 +: 8] = w[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_pick(input logic [31:0] d, input logic [1:0] off, input logic [1:0] s);
    logic [31:0] r = '0;
    for (int k = 0; k < nbytes(s); k++) r[k*8 +: 8] = d[(int'(off)+k)*8 +: 8];
    return r;
  endfunction

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    prb_sel = s;
    #1;
    v = prb_rdata;
  endtask

  task automatic pwr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    prb_sel = s; prb_wdata = v; prb_wr = 1'b1;
    @(negedge clk);
    prb_wr = 1'b0;
  endtask

  // one full access: issue, inspect, service, complete
  task automatic service(input logic we, input logic [1:0] s, input logic [31:0] a,
                         input logic [31:0] w, input logic [31:0] rv);
    logic [31:0] v;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_size = s; cpu_addr = a; cpu_wdata = w;
    @(negedge clk);
    rd(2'd0, v);
    check("R2 ctrl after capture", v, 32'h10 | (32'(s) << 2) | (32'(we) << 1) | 32'h1);
    rd(2'd1, v);
    check("R2 address", v, a);
    check("R4 stalled", 32'(cpu_ready), 32'h0);
    if (we) begin
      rd(2'd2, v);
      check("R6 store lanes", v, exp_place(w, a[1:0], s));
    end else begin
      pwr(2'd2, rv);
    end
    @(negedge clk);
    check("R4 still stalled", 32'(cpu_ready), 32'h0);
    pwr(2'd0, 32'h10);
    check("R5 ready", 32'(cpu_ready), 32'h1);
    check("R7 rdata", cpu_rdata, we ? exp_pick(exp_place(w, a[1:0], s), a[1:0], s)
                                    : exp_pick(rv, a[1:0], s));
    rd(2'd0, v);
    check("R5 pend cleared", v & 32'h1, 32'h0);
    cpu_req = 1'b0;
    @(negedge clk);
    check("R5 ready one cycle", 32'(cpu_ready), 32'h0);
    check("R7 rdata idle", cpu_rdata, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog R4 actual=%0d expected<50000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7741));
    @(negedge clk);
    rd(2'd0, v);
    check("R1 reset ctrl", v, 32'h30);
    check("R1 reset ready", 32'(cpu_ready), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: write under reset-seen with bit5 set is dropped
    pwr(2'd0, 32'h20);
    rd(2'd0, v);
    check("R8 dropped write", v, 32'h30);
    // R9: acknowledge
    pwr(2'd0, 32'h10);
    rd(2'd0, v);
    check("R9 ack", v, 32'h10);
    // R11: probe cannot set reset-seen
    pwr(2'd0, 32'h30);
    rd(2'd0, v);
    check("R11 rseen stays clear", v, 32'h10);

    // R3: routing disabled
    pwr(2'd0, 32'h00);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 2'd2; cpu_addr = 32'h0000_0040;
    repeat (3) @(negedge clk);
    rd(2'd0, v);
    check("R3 not pending", v & 32'h1, 32'h0);
    check("R3 no ready", 32'(cpu_ready), 32'h0);
    pwr(2'd0, 32'h10);
    @(negedge clk);
    rd(2'd0, v);
    check("R2 captured once routed", v, 32'h19);
    pwr(2'd0, 32'h10);
    check("R5 ready after route", 32'(cpu_ready), 32'h1);
    cpu_req = 1'b0;
    @(negedge clk);

    // directed halfword store example
    service(1'b1, 2'd1, 32'hFF20_1232, 32'h0000_5678, 32'h0);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 2'd1; cpu_addr = 32'hFF20_1232; cpu_wdata = 32'h5678;
    @(negedge clk);
    rd(2'd2, v);
    check("R6 halfword example", v, 32'h5678_0000);
    pwr(2'd0, 32'h10);
    cpu_req = 1'b0;
    @(negedge clk);

    // random accesses
    for (int i = 0; i < 40; i++) begin
      logic [1:0] s;
      logic [31:0] a;
      s = 2'($urandom_range(0, 2));
      a = $urandom;
      if (s == 2'd1) a[0] = 1'b0;
      if (s == 2'd2) a[1:0] = 2'b00;
      service(1'($urandom), s, a, $urandom, $urandom);
    end

    // R10 / R8 / R9: reset during a pending access
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_size = 2'd0; cpu_addr = 32'h0000_0103;
    @(negedge clk);
    rd(2'd0, v);
    check("R2 pending before reset", v & 32'h1, 32'h1);
    rst_n = 1'b0;
    #2;
    rd(2'd0, v);
    check("R10 reset clears pend sets rseen", v, 32'h30);
    @(negedge clk);
    check("R10 no ready in reset", 32'(cpu_ready), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v);
    check("R10 new access pending", v & 32'h21, 32'h21);
    pwr(2'd0, 32'h30);
    rd(2'd0, v);
    check("R8 clear blocked", v & 32'h21, 32'h21);
    check("R8 no ready", 32'(cpu_ready), 32'h0);
    pwr(2'd2, 32'h0000_AB00);
    pwr(2'd0, 32'h11);
    rd(2'd0, v);
    check("R9 ack keeps pending", v & 32'h21, 32'h01);
    pwr(2'd0, 32'h10);
    check("R5 completes after ack", 32'(cpu_ready), 32'h1);
    check("R7 byte offset 3", cpu_rdata, 32'h0);
    cpu_req = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule